// File: doc/BRIEF.md
# Edge Interval Bit Checker

This block decides whether a demodulated serial stream looks like real data before any decoding starts. It measures the time between successive transitions of the data input by counting periods of a slow check clock, which reaches the block as a one-cycle tick strobe in the system clock domain. Each measured interval is compared against a programmable acceptance window. An interval that is too short fails the check, and so does one that is too long. The block then drops back to sleep.

After a rising enable, the block first waits out a programmable startup period while the front end settles, and the data input is ignored during that wait. It then enters bit check mode. A set number of consecutive good intervals completes the check. The block then raises a one-cycle done strobe and holds a pass level until enable is removed. A window and a startup length can be loaded while the block is asleep. Both polarities of data transition are timed alike.

Top module: `edge_interval_checker`

## Requirements
- R1: After reset the mode output reads sleep (mode encoding: 0 sleep, 1 startup, 2 bit check, 3 done), all result outputs are low, the window is lower limit 14 and upper limit 24, and the startup length is 8 ticks.
- R2: A rising edge of enable seen in sleep enters startup. Startup lasts exactly startup-length ticks (a length of 0 behaves as 1), and bit check then begins with the interval count at 0.
- R3: Data transitions during startup produce no pass or fail result.
- R4: In bit check the interval count rises by one per tick. After a passing transition it restarts, so the next tick makes it 1. A transition is judged three system clocks after the data input changes.
- R5: A transition seen with the count below the lower limit pulses checkFail for one cycle and returns the mode to sleep.
- R6: A transition seen with the count at or above the lower limit and below the upper limit pulses checkPass for one cycle.
- R7: When a tick brings the count to the upper limit, checkFail pulses and the mode returns to sleep without any transition.
- R8: PASS_NEED consecutive passes (default 3, counted from each entry into bit check) pulse checkDone together with the last checkPass. The mode becomes done, passHold goes high, and no further result is produced while enable stays high.
- R9: Enable low returns the mode to sleep on the next cycle from any mode and clears passHold.
- R10: After a fail, the block stays in sleep while enable remains high. Only a new low-to-high enable restarts it.
- R11: A configuration write loads lower limit, upper limit and startup length only while the mode is sleep. A write in any other mode has no effect.
- R12: Rising and falling data transitions are timed and judged alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; a rising edge starts a check cycle |
| xTick | input | 1 | One-cycle strobe per check clock period |
| dataIn | input | 1 | Demodulated data, asynchronous |
| cfgWrite | input | 1 | Load strobe for the three configuration values |
| cfgLimLo | input | 6 | Lower limit of the interval window |
| cfgLimHi | input | 6 | Upper limit of the interval window |
| cfgStartup | input | 8 | Startup length in ticks |
| mode | output | 2 | 0 sleep, 1 startup, 2 bit check, 3 done |
| checkPass | output | 1 | One-cycle pulse per accepted interval |
| checkFail | output | 1 | One-cycle pulse when the check aborts |
| checkDone | output | 1 | One-cycle pulse when the required passes are reached |
| passHold | output | 1 | High from done until enable falls |

## Verification
On every cycle, the assertions check these mode rules: a fail always lands in sleep, pass and fail never coincide, a done pulse brings the hold level and the done mode, disabling always yields sleep, and the window cannot change outside sleep. Whether a given interval passes or fails depends on counting ticks against the window. Only the bench's scenarios show this: the exact boundaries at the lower limit, one below the upper limit, and the timeout at the upper limit. The scenarios also cover the exact startup length, the need for a fresh enable edge after a fail, and the silent discard of transitions during startup.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_CHECK   = 2'd2,
    MODE_DONE    = 2'd3
  } eicMode_e;

  typedef struct packed {
    logic cfgLoad;
    logic startClear;
    logic startInc;
    logic cntClear;
    logic cntInc;
    logic passClear;
    logic passInc;
  } eicStrobe_t;

  typedef struct packed {
    logic edgeSeen;
    logic belowLo;
    logic hitHi;
    logic startDone;
    logic passLast;
  } eicStatus_t;
endpackage

// File: rtl/eic_datapath.sv
module eic_datapath
  import eic_pkg::*;
#(
  parameter int LIM_W       = 6,
  parameter int START_W     = 8,
  parameter int PASS_NEED   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LO_DEF      = 14,
  parameter int HI_DEF      = 24,
  parameter int START_DEF   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dataIn,
  input  logic [LIM_W-1:0]   cfgLimLo,
  input  logic [LIM_W-1:0]   cfgLimHi,
  input  logic [START_W-1:0] cfgStartup,
  input  eicStrobe_t         sb,
  output eicStatus_t         st,
  output logic [LIM_W-1:0]   limLoQ,
  output logic [LIM_W-1:0]   limHiQ
);
  localparam int PASS_W = (PASS_NEED > 1) ? $clog2(PASS_NEED) : 1;
  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASS_NEED - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic [LIM_W-1:0]       intCnt;
  logic [START_W-1:0]     startCnt;
  logic [START_W-1:0]     startLen;
  logic [PASS_W-1:0]      passCnt;
  logic [LIM_W:0]         cntNext;
  logic [START_W:0]       startNext;

  // synchronizer chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else if (gi == 0) syncQ[gi] <= dataIn;
        else syncQ[gi] <= syncQ[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else lastQ <= syncQ[SYNC_STAGES-1];
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limLoQ   <= LIM_W'(LO_DEF);
      limHiQ   <= LIM_W'(HI_DEF);
      startLen <= START_W'(START_DEF);
    end else if (sb.cfgLoad) begin
      limLoQ   <= cfgLimLo;
      limHiQ   <= cfgLimHi;
      startLen <= cfgStartup;
    end
  end

  // interval counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intCnt <= '0;
    else if (sb.cntClear) intCnt <= '0;
    else if (sb.cntInc && intCnt != CNT_MAX) intCnt <= intCnt + 1'b1;
  end

  // startup counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startCnt <= '0;
    else if (sb.startClear) startCnt <= '0;
    else if (sb.startInc) startCnt <= startCnt + 1'b1;
  end

  // consecutive pass counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) passCnt <= '0;
    else if (sb.passClear) passCnt <= '0;
    else if (sb.passInc) passCnt <= passCnt + 1'b1;
  end

  assign cntNext   = {1'b0, intCnt} + 1'b1;
  assign startNext = {1'b0, startCnt} + 1'b1;

  always_comb begin
    st.edgeSeen  = syncQ[SYNC_STAGES-1] ^ lastQ;
    st.belowLo   = intCnt < limLoQ;
    st.hitHi     = cntNext >= {1'b0, limHiQ};
    st.startDone = startNext >= {1'b0, startLen};
    st.passLast  = (PASS_NEED <= 1) ? 1'b1 : (passCnt == PASS_LAST);
  end
endmodule

// File: rtl/eic_control.sv
module eic_control
  import eic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       xTick,
  input  logic       cfgWrite,
  input  eicStatus_t st,
  output eicStrobe_t sb,
  output eicMode_e   mode,
  output logic       checkPass,
  output logic       checkFail,
  output logic       checkDone,
  output logic       passHold
);
  eicMode_e state, nextState;
  logic     enPrev;
  logic     passNow, failNow, doneNow;

  always_comb begin
    nextState = state;
    sb        = '0;
    passNow   = 1'b0;
    failNow   = 1'b0;
    doneNow   = 1'b0;
    sb.cfgLoad = (state == MODE_SLEEP) && cfgWrite;
    case (state)
      MODE_SLEEP: begin
        if (enable && !enPrev) begin
          nextState     = MODE_STARTUP;
          sb.startClear = 1'b1;
        end
      end
      MODE_STARTUP: begin
        if (xTick) begin
          sb.startInc = 1'b1;
          if (st.startDone) begin
            nextState    = MODE_CHECK;
            sb.cntClear  = 1'b1;
            sb.passClear = 1'b1;
          end
        end
      end
      MODE_CHECK: begin
        if (st.edgeSeen) begin
          if (st.belowLo) begin
            failNow   = 1'b1;
            nextState = MODE_SLEEP;
          end else begin
            passNow     = 1'b1;
            sb.cntClear = 1'b1;
            sb.passInc  = 1'b1;
            if (st.passLast) begin
              doneNow   = 1'b1;
              nextState = MODE_DONE;
            end
          end
        end else if (xTick) begin
          if (st.hitHi) begin
            failNow   = 1'b1;
            nextState = MODE_SLEEP;
          end else begin
            sb.cntInc = 1'b1;
          end
        end
      end
      default: nextState = MODE_DONE;
    endcase
    if (!enable) begin
      nextState = MODE_SLEEP;
      passNow   = 1'b0;
      failNow   = 1'b0;
      doneNow   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= MODE_SLEEP;
      enPrev    <= 1'b0;
      checkPass <= 1'b0;
      checkFail <= 1'b0;
      checkDone <= 1'b0;
      passHold  <= 1'b0;
    end else begin
      state     <= nextState;
      enPrev    <= enable;
      checkPass <= passNow;
      checkFail <= failNow;
      checkDone <= doneNow;
      if (!enable) passHold <= 1'b0;
      else if (doneNow) passHold <= 1'b1;
    end
  end

  assign mode = state;
endmodule

// File: rtl/edge_interval_checker.sv
module edge_interval_checker
  import eic_pkg::*;
#(
  parameter int LIM_W       = 6,
  parameter int START_W     = 8,
  parameter int PASS_NEED   = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LO_DEF      = 14,
  parameter int HI_DEF      = 24,
  parameter int START_DEF   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               xTick,
  input  logic               dataIn,
  input  logic               cfgWrite,
  input  logic [LIM_W-1:0]   cfgLimLo,
  input  logic [LIM_W-1:0]   cfgLimHi,
  input  logic [START_W-1:0] cfgStartup,
  output logic [1:0]         mode,
  output logic               checkPass,
  output logic               checkFail,
  output logic               checkDone,
  output logic               passHold
);
  eicStrobe_t       sb;
  eicStatus_t       st;
  eicMode_e         modeQ;
  logic [LIM_W-1:0] limLoQ;
  logic [LIM_W-1:0] limHiQ;

  eic_datapath #(
    .LIM_W(LIM_W), .START_W(START_W), .PASS_NEED(PASS_NEED),
    .SYNC_STAGES(SYNC_STAGES), .LO_DEF(LO_DEF), .HI_DEF(HI_DEF),
    .START_DEF(START_DEF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .cfgLimLo(cfgLimLo), .cfgLimHi(cfgLimHi), .cfgStartup(cfgStartup),
    .sb(sb), .st(st), .limLoQ(limLoQ), .limHiQ(limHiQ)
  );

  eic_control u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .xTick(xTick),
    .cfgWrite(cfgWrite), .st(st), .sb(sb), .mode(modeQ),
    .checkPass(checkPass), .checkFail(checkFail),
    .checkDone(checkDone), .passHold(passHold)
  );

  assign mode = modeQ;
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int LIM_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [1:0]       mode,
  input logic             checkPass,
  input logic             checkFail,
  input logic             checkDone,
  input logic             passHold,
  input logic [LIM_W-1:0] limLoQ,
  input logic [LIM_W-1:0] limHiQ
);
  AST_FAIL_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    checkFail |-> mode == 2'd0); // R5
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(checkPass && checkFail)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |-> (passHold && checkPass && mode == 2'd3)); // R8
  AST_OFF_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (mode == 2'd0 && !passHold)); // R9
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    mode != 2'd0 |=> ($stable(limLoQ) && $stable(limHiQ))); // R11
  AST_STARTUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    mode == 2'd1 |-> !(checkPass || checkFail)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> !(checkPass || checkFail)); // R8
endmodule

bind edge_interval_checker eic_checker #(.LIM_W(LIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
  .checkPass(checkPass), .checkFail(checkFail), .checkDone(checkDone),
  .passHold(passHold), .limLoQ(limLoQ), .limHiQ(limHiQ)
);

// File: tb/sim_edge_interval_checker.sv
`timescale 1ns/1ps
module sim_edge_interval_checker;
  localparam int EV_PASS = 0;
  localparam int EV_DONE = 1;
  localparam int EV_FAIL = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       xTick = 1'b0;
  logic       dataIn = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [5:0] cfgLimLo = '0;
  logic [5:0] cfgLimHi = '0;
  logic [7:0] cfgStartup = '0;
  logic [1:0] mode;
  logic       checkPass, checkFail, checkDone, passHold;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    expQ[$];
  string tagQ[$];
  int    phase = 0;
  bit    finished = 0;

  edge_interval_checker u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .xTick(xTick), .dataIn(dataIn),
    .cfgWrite(cfgWrite), .cfgLimLo(cfgLimLo), .cfgLimHi(cfgLimHi),
    .cfgStartup(cfgStartup), .mode(mode), .checkPass(checkPass),
    .checkFail(checkFail), .checkDone(checkDone), .passHold(passHold)
  );

  always #10 clk = ~clk;

  // check-clock tick: one system cycle in four
  always @(negedge clk) begin
    xTick = (phase == 0);
    phase = (phase + 1) % 4;
  end

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int ev, input string tag);
    expQ.push_back(ev);
    tagQ.push_back(tag);
  endtask

  // monitor: pops expected events as results appear
  task automatic take(input int ev);
    if (expQ.size() == 0) begin
      testsRun++;
      testsFailed++;
      $display("FAIL unexpected result actual=%0d expected=none", ev);
    end else begin
      int    e = expQ.pop_front();
      string t = tagQ.pop_front();
      check(t, ev, e);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (checkPass) take(EV_PASS);
      if (checkDone) take(EV_DONE);
      if (checkFail) take(EV_FAIL);
    end
  end

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!xTick) @(posedge clk);
    end
  endtask

  task automatic toggle();
    @(negedge clk);
    dataIn = ~dataIn;
  endtask

  // rising enable after a tick; returns number of ticks spent in startup
  task automatic startUp(output int n, input bit dirtyData);
    waitTicks(1);
    @(negedge clk);
    enable = 1'b1;
    n = 0;
    do begin
      waitTicks(1);
      n++;
      @(negedge clk);
      if (dirtyData && n == 2) dataIn = ~dataIn;
    end while (mode != 2'd2 && n < 100);
  endtask

  task automatic writeCfg(input int lo, input int hi, input int su);
    @(negedge clk);
    cfgWrite = 1'b1;
    cfgLimLo = 6'(lo);
    cfgLimHi = 6'(hi);
    cfgStartup = 8'(su);
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic disableBlock();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 outputs", {checkPass, checkFail, checkDone, passHold}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mode after release", mode, 0);

    // R2/R3 default startup, data toggle in startup ignored
    startUp(n, 1'b1);
    check("R2 startup ticks", n, 8);
    check("R2 in check", mode, 2);
    // R6/R12/R4 boundaries: 14 (lower), 23 (upper-1), 18
    expect_ev(EV_PASS, "R6 interval at lower limit");
    waitTicks(14); toggle();
    expect_ev(EV_PASS, "R4 R12 interval upper-1");
    waitTicks(23); toggle();
    expect_ev(EV_PASS, "R8 third pass");
    expect_ev(EV_DONE, "R8 done pulse");
    waitTicks(18); toggle();
    repeat (4) @(negedge clk);
    check("R8 mode done", mode, 3);
    check("R8 passHold", passHold, 1);
    waitTicks(30);
    @(negedge clk);
    check("R8 stays done", mode, 3);

    // R9 disable
    disableBlock();
    check("R9 mode sleep", mode, 0);
    check("R9 passHold cleared", passHold, 0);

    // R5 too short
    startUp(n, 1'b0);
    expect_ev(EV_FAIL, "R5 interval below lower");
    waitTicks(13); toggle();
    repeat (4) @(negedge clk);
    check("R5 back to sleep", mode, 0);

    // R10 enable still high: stays asleep
    waitTicks(12);
    @(negedge clk);
    check("R10 no restart", mode, 0);
    disableBlock();

    // R7 timeout at upper limit
    startUp(n, 1'b0);
    waitTicks(23);
    @(negedge clk);
    check("R7 still checking at upper-1", mode, 2);
    expect_ev(EV_FAIL, "R7 upper limit timeout");
    waitTicks(1);
    @(negedge clk);
    check("R7 sleep at upper", mode, 0);
    disableBlock();

    // R11 write in sleep: window 10..12, startup 3
    writeCfg(10, 12, 3);
    startUp(n, 1'b0);
    check("R11 R2 new startup", n, 3);
    expect_ev(EV_PASS, "R11 new lower limit");
    waitTicks(10); toggle();
    expect_ev(EV_PASS, "R11 new upper-1");
    waitTicks(11); toggle();
    // R11 write during check ignored
    writeCfg(5, 40, 1);
    expect_ev(EV_FAIL, "R11 write ignored in check");
    waitTicks(8); toggle();
    repeat (4) @(negedge clk);
    check("R11 fail sleep", mode, 0);
    disableBlock();

    // R2 startup length 0 behaves as 1
    writeCfg(10, 12, 0);
    startUp(n, 1'b0);
    check("R2 zero startup", n, 1);
    expect_ev(EV_FAIL, "R7 new upper limit");
    waitTicks(12);
    repeat (2) @(negedge clk);
    disableBlock();

    repeat (8) @(negedge clk);
    check("queue drained", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule